// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer/Counter

This block is an 8-bit counter with two compare channels. Each channel watches the count and, on a match, raises a flag and flips its own waveform output. A count step comes from one of two places. The first is a one-cycle enable from an external prescaler. The second is a chosen edge on an external count pin, which is first brought into the clock domain. The highest value of the count sequence is either the fixed value 0xFF or the value held in compare register A. The counter either counts up and wraps, or counts up and down between zero and that ceiling.

Software reaches the block through a register port with a single write port and a separate combinational read port. That port covers the counter, both compare values, the control bits, a write-one-to-clear flag register and a mask register. One interrupt line is high whenever a flag is set and its mask bit is also set.

Top module: `tc8_dual_cmp`

## Requirements
- R1: After reset, every register reads zero, both waveform outputs are low and the interrupt line is low.
- R2: The register addresses are: 0 counter, 1 compare A, 2 compare B, 3 control, 4 flags, 5 mask. A write to address 1, 2, 3 or 5 is visible on the read port after the clock edge that takes it. Addresses 6 and 7 read zero. Control and mask use bits [3:0] and [2:0]; their unused bits read zero.
- R3: Control bit 0 selects the count source: 0 takes the prescaler enable input, and 1 takes the synchronised pin edge. The source that is not selected has no effect on the count.
- R4: The count pin passes through a two-stage synchroniser. Control bit 1 selects the rising edge (0) or the falling edge (1). A pin level first sampled at clock edge k advances the counter at edge k+2, by exactly one step.
- R5: In normal mode (control bit 3 = 0), a count step adds one. A step taken while the count equals TOP (or 0xFF) loads 0x00 and sets the overflow flag.
- R6: Control bit 2 selects TOP: 0 gives 0xFF, and 1 gives the value of compare register A.
- R7: In up/down mode (control bit 3 = 1), the counter counts up until a step taken at or above TOP, which turns it downward. It counts down until a step taken at 0x00, which turns it upward and sets the overflow flag.
- R8: A count step taken while the count equals a compare value sets that channel's flag and toggles that channel's waveform output at the same edge.
- R9: Flag bits are: bit 0 overflow, bit 1 compare A, bit 2 compare B. Writing 1 to a bit clears it. A set event in the same cycle wins over the clear.
- R10: The interrupt line is high exactly when some flag bit is set while the mask bit at the same position (mask bits [2:0]) is set.
- R11: A write to the counter replaces the count in that cycle even if a count step is present. The first count step after the write makes no compare match, although it still advances the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block on the clock |
| presc_tick | input | 1 | Count enable from the external prescaler |
| ext_pin | input | 1 | Asynchronous external count pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W (8) | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | W (8) | Register read data, combinational from rd_addr |
| wave_a | output | 1 | Toggle output of compare channel A |
| wave_b | output | 1 | Toggle output of compare channel B |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The assertions assume that reset is applied at start-up, that the count pin holds each level for at least one clock period, and that write strobes are known (never X) whenever reset is inactive. The bench changes every input half a period away from the active edge, so every pin level is held for a full cycle before the synchroniser sees it. A behavioural model in the bench follows each edge and is compared against the read port, both waveforms and the interrupt line on every cycle. Directed sequences cover the wrap points, the turn points, the edge choice, the compare-suppression window and the priority of set over clear. A random phase then mixes count steps, pin activity and register writes.

// File: rtl/tc8_pkg.sv
package tc8_pkg;

  // register port addresses
  localparam logic [2:0] A_CNT  = 3'd0;
  localparam logic [2:0] A_CMP0 = 3'd1;
  localparam logic [2:0] A_CMP1 = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_FLAG = 3'd4;
  localparam logic [2:0] A_MASK = 3'd5;

  localparam int NCMP        = 2;
  localparam int NFLAG       = NCMP + 1;
  localparam int FLG_OVF     = 0;
  localparam int FLG_CMP0    = 1;
  localparam int SYNC_STAGES = 2;
  localparam int CTRL_W      = 4;

  typedef struct packed {
    logic mode_ud;   // bit 3
    logic top_sel;   // bit 2
    logic edge_fall; // bit 1
    logic src_ext;   // bit 0
  } tc8_ctrl_t;

endpackage

// File: rtl/tc8_pin_sync.sv
module tc8_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_fall,
  output logic pulse
);

  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LEN-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its history
  always_comb begin
    if (edge_fall) pulse = ~chain_q[STAGES-1] &  chain_q[STAGES];
    else           pulse =  chain_q[STAGES-1] & ~chain_q[STAGES];
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/tc8_counter.sv
module tc8_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         mode_ud,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         cmp_en
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         skip_q, skip_d;

  always_comb begin
    cnt_d   = cnt_q;
    down_d  = down_q;
    skip_d  = skip_q;
    ovf_evt = 1'b0;
    cmp_en  = 1'b0;
    if (wr) begin
      cnt_d  = wdata;
      skip_d = 1'b1;
    end else if (tick) begin
      skip_d = 1'b0;
      cmp_en = !skip_q;
      if (!mode_ud) begin
        down_d = 1'b0;
        if (cnt_q == top || cnt_q == MAXV) begin
          cnt_d   = ZERO;
          ovf_evt = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (!down_q) begin
        if (cnt_q >= top) begin
          down_d = 1'b1;
          cnt_d  = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == ZERO) begin
          down_d  = 1'b0;
          ovf_evt = 1'b1;
          cnt_d   = (top == ZERO) ? ZERO : ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      skip_q <= skip_d;
    end
  end

  assign cnt = cnt_q;

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt_q == $past(wdata));

  a_r5_wrap_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && !mode_ud && cnt_q == top) |=> cnt_q == ZERO);

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(cnt_q));

  a_r7_bottom_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && mode_ud && down_q && cnt_q == ZERO) |=> !down_q);

endmodule

// File: rtl/tc8_cmp_unit.sv
module tc8_cmp_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_en,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_val,
  output logic         match,
  output logic         wave
);

  logic wave_q, wave_d;

  always_comb begin
    match  = cmp_en && (cnt == cmp_val);
    wave_d = wave_q;
    if (match) wave_d = ~wave_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave = wave_q;

  a_r8_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> wave_q != $past(wave_q));

  a_r8_hold_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(wave_q));

endmodule

// File: rtl/tc8_dual_cmp.sv
module tc8_dual_cmp
  import tc8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         presc_tick,
  input  logic         ext_pin,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         wave_a,
  output logic         wave_b,
  output logic         irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  // register state
  tc8_ctrl_t        ctrl_q, ctrl_d;
  logic [NFLAG-1:0] flag_q, flag_d;
  logic [NFLAG-1:0] mask_q, mask_d;
  logic [W-1:0]     cmp_q [NCMP];
  logic [NCMP-1:0]  match;
  logic [NCMP-1:0]  wave;
  logic [NFLAG-1:0] evt;

  logic         ext_pulse;
  logic         tick_sel;
  logic [W-1:0] top_val;
  logic [W-1:0] cnt;
  logic         ovf_evt;
  logic         cmp_en;
  logic         wr_cnt;

  assign wr_cnt = wr_en && (wr_addr == A_CNT);

  tc8_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ns),
    .pin       (ext_pin),
    .edge_fall (ctrl_q.edge_fall),
    .pulse     (ext_pulse)
  );

  always_comb begin
    tick_sel = ctrl_q.src_ext ? ext_pulse : presc_tick;
    top_val  = ctrl_q.top_sel ? cmp_q[0] : {W{1'b1}};
  end

  tc8_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_ns),
    .tick    (tick_sel),
    .wr      (wr_cnt),
    .wdata   (wr_data),
    .mode_ud (ctrl_q.mode_ud),
    .top     (top_val),
    .cnt     (cnt),
    .ovf_evt (ovf_evt),
    .cmp_en  (cmp_en)
  );

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic         cmp_wr;
    logic [W-1:0] cmp_d;

    always_comb begin
      cmp_wr = wr_en && (wr_addr == (A_CMP0 + 3'(i)));
      cmp_d  = cmp_wr ? wr_data : cmp_q[i];
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) cmp_q[i] <= '0;
      else         cmp_q[i] <= cmp_d;
    end

    tc8_cmp_unit #(.W(W)) u_unit (
      .clk     (clk),
      .rst_n   (rst_ns),
      .cmp_en  (cmp_en),
      .cnt     (cnt),
      .cmp_val (cmp_q[i]),
      .match   (match[i]),
      .wave    (wave[i])
    );

    assign evt[FLG_CMP0+i] = match[i];

    a_r9_cmp_flag_set: assert property (@(posedge clk) disable iff (!rst_ns)
      match[i] |=> flag_q[FLG_CMP0+i]);
  end

  assign evt[FLG_OVF] = ovf_evt;

  // control, mask and flag next state
  always_comb begin
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    flag_d = flag_q;
    if (wr_en && wr_addr == A_CTRL) ctrl_d = tc8_ctrl_t'(wr_data[CTRL_W-1:0]);
    if (wr_en && wr_addr == A_MASK) mask_d = wr_data[NFLAG-1:0];
    if (wr_en && wr_addr == A_FLAG) flag_d = flag_q & ~wr_data[NFLAG-1:0];
    flag_d = flag_d | evt;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  // read port
  always_comb begin
    case (rd_addr)
      A_CNT:   rd_data = cnt;
      A_CMP0:  rd_data = cmp_q[0];
      A_CMP1:  rd_data = cmp_q[1];
      A_CTRL:  rd_data = {{(W-CTRL_W){1'b0}}, ctrl_q};
      A_FLAG:  rd_data = {{(W-NFLAG){1'b0}}, flag_q};
      A_MASK:  rd_data = {{(W-NFLAG){1'b0}}, mask_q};
      default: rd_data = '0;
    endcase
  end

  assign irq    = |(flag_q & mask_q);
  assign wave_a = wave[0];
  assign wave_b = wave[1];

  a_r9_ovf_flag_set: assert property (@(posedge clk) disable iff (!rst_ns)
    ovf_evt |=> flag_q[FLG_OVF]);

  a_r3_pin_ignored: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ctrl_q.src_ext && !presc_tick && !wr_cnt) |=> $stable(cnt));

endmodule

// File: tb/tc8_dual_cmp_tb.sv
module tc8_dual_cmp_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       presc_tick, ext_pin, wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       wave_a, wave_b, irq;

  always #5 clk = ~clk;

  tc8_dual_cmp u_dut (
    .clk, .rst_n, .presc_tick, .ext_pin, .wr_en, .wr_addr, .wr_data,
    .rd_addr, .rd_data, .wave_a, .wave_b, .irq
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_down, m_skip, m_ctrl, m_flags, m_mask;
  int m_cmp[2];
  int m_wave[2];
  int m_s1, m_s2, m_s3;

  function automatic int model_rd(int a);
    case (a)
      0: return m_cnt;
      1: return m_cmp[0];
      2: return m_cmp[1];
      3: return m_ctrl;
      4: return m_flags;
      5: return m_mask;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_skip = 0; m_ctrl = 0; m_flags = 0; m_mask = 0;
      m_cmp[0] = 0; m_cmp[1] = 0; m_wave[0] = 0; m_wave[1] = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      int pulse, tick, top, ovf, cen, wcnt, nf;
      int mt[2];
      int nc, nd;
      pulse = (m_ctrl & 2) ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
      tick  = (m_ctrl & 1) ? pulse : int'(presc_tick);
      top   = (m_ctrl & 4) ? m_cmp[0] : 255;
      wcnt  = wr_en && wr_addr == 0;
      ovf = 0; cen = 0; nc = m_cnt; nd = m_down;
      if (wcnt) begin
        nc = wr_data; m_skip = 1;
      end else if (tick) begin
        cen = !m_skip; m_skip = 0;
        if (!(m_ctrl & 8)) begin
          nd = 0;
          if (m_cnt == top || m_cnt == 255) begin nc = 0; ovf = 1; end
          else nc = m_cnt + 1;
        end else if (!m_down) begin
          if (m_cnt >= top) begin nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else nc = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nd = 0; ovf = 1; nc = (top == 0) ? 0 : 1; end
          else nc = m_cnt - 1;
        end
      end
      for (int i = 0; i < 2; i++) begin
        mt[i] = cen && (m_cnt == m_cmp[i]);
        if (mt[i]) m_wave[i] = 1 - m_wave[i];
      end
      nf = m_flags;
      if (wr_en && wr_addr == 4) nf = nf & ~int'(wr_data) & 7;
      nf = nf | ovf | (mt[0] << 1) | (mt[1] << 2);
      m_flags = nf;
      if (wr_en && wr_addr == 1) m_cmp[0] = wr_data;
      if (wr_en && wr_addr == 2) m_cmp[1] = wr_data;
      if (wr_en && wr_addr == 3) m_ctrl = wr_data & 15;
      if (wr_en && wr_addr == 5) m_mask = wr_data & 7;
      m_cnt = nc; m_down = nd;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    end
  end

  // every-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && cmp_on && !done) begin
      chk(cur_req, rd_data, model_rd(rd_addr));
      chk(cur_req, wave_a, m_wave[0]);
      chk(cur_req, wave_b, m_wave[1]);
      chk(cur_req, irq, (m_flags & m_mask) != 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tick1();
    @(negedge clk); presc_tick = 1;
    @(negedge clk); presc_tick = 0;
  endtask

  task automatic peek(string req, int a, int exp);
    rd_addr = 3'(a); #1;
    chk(req, rd_data, exp);
    rd_addr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run did not finish, got hang expected end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int wb;
    int ud_exp[7];
    ud_exp = '{1, 2, 3, 2, 1, 0, 1};
    rst_n = 0; presc_tick = 0; ext_pin = 0; wr_en = 0;
    wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 6; a++) peek("R1", a, 0);
    chk("R1", wave_a, 0); chk("R1", wave_b, 0); chk("R1", irq, 0);

    // R2 register map and readback
    cur_req = "R2";
    wr(1, 8'h80); wr(2, 8'h10); wr(5, 8'hF8); wr(3, 8'hF0);
    peek("R2", 1, 8'h80); peek("R2", 2, 8'h10);
    peek("R2", 5, 0); peek("R2", 3, 0); peek("R2", 6, 0); peek("R2", 7, 0);

    // R5 normal wrap at 0xFF
    cur_req = "R5";
    wr(0, 8'hFE); wr(4, 7);
    tick1(); peek("R5", 0, 8'hFF); peek("R5", 4, 0);
    tick1(); peek("R5", 0, 8'h00); peek("R5", 4, 1);

    // R10 mask gating, R9 write-one-to-clear
    cur_req = "R10";
    chk("R10", irq, 0);
    wr(5, 1); chk("R10", irq, 1);
    cur_req = "R9";
    wr(4, 1); peek("R9", 4, 0); chk("R9", irq, 0);

    // R6 TOP from compare A
    cur_req = "R6";
    wr(1, 5); wr(3, 4); wr(0, 4); wr(4, 7);
    tick1(); peek("R6", 0, 5);
    tick1(); peek("R6", 0, 0); peek("R6", 4, 1 | 2);

    // R8 compare match toggles and flags
    cur_req = "R8";
    wr(3, 0); wr(1, 8'h80); wr(2, 8'h10); wr(0, 8'h0E); wr(4, 7);
    wb = wave_b;
    tick1(); tick1();
    peek("R8", 0, 8'h10); chk("R8", wave_b, wb);
    tick1(); chk("R8", wave_b, 1 - wb); peek("R8", 4, 4);

    // R11 write wins over a tick, next match suppressed
    cur_req = "R11";
    wr(4, 7); wb = wave_b;
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 8'h10; presc_tick = 1;
    @(negedge clk); wr_en = 0;
    peek("R11", 0, 8'h10);
    @(negedge clk); presc_tick = 0;
    peek("R11", 0, 8'h11); chk("R11", wave_b, wb); peek("R11", 4, 0);

    // R7 up/down with TOP = compare A = 3
    cur_req = "R7";
    wr(1, 3); wr(3, 8'h0C); wr(0, 0);
    for (int k = 0; k < 7; k++) begin
      if (k == 0) wr(4, 7);
      tick1();
      peek("R7", 0, ud_exp[k]);
      rd_addr = 4; #1; chk("R7", rd_data & 1, (k == 6) ? 1 : 0); rd_addr = 0;
    end
    repeat (40) tick1();

    // R3 + R4 pin source, rising edge, prescaler ignored
    cur_req = "R4";
    wr(3, 1); wr(0, 0);
    @(negedge clk); presc_tick = 1;
    repeat (3) @(negedge clk);
    peek("R3", 0, 0);
    ext_pin = 1;
    @(negedge clk); @(negedge clk);
    peek("R4", 0, 0);
    @(negedge clk);
    peek("R4", 0, 1);
    repeat (3) @(negedge clk);
    peek("R4", 0, 1);
    ext_pin = 0;
    repeat (4) @(negedge clk);
    peek("R4", 0, 1);
    // falling edge select
    wr(3, 3);
    ext_pin = 1; repeat (4) @(negedge clk);
    peek("R4", 0, 1);
    ext_pin = 0; repeat (3) @(negedge clk);
    peek("R4", 0, 2);
    presc_tick = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); ext_pin = ((k % 3) == 0) ? ~ext_pin : ext_pin;
    end

    // R9 set wins over clear in the same cycle
    cur_req = "R9";
    wr(3, 0); wr(0, 8'hFF);
    @(negedge clk); presc_tick = 1; wr_en = 1; wr_addr = 4; wr_data = 8'h07;
    @(negedge clk); presc_tick = 0; wr_en = 0;
    rd_addr = 4; #1; chk("R9", rd_data & 1, 1); rd_addr = 0;

    // mixed random traffic
    cur_req = "R8";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      presc_tick = ($urandom % 3) == 0;
      if (($urandom % 5) == 0) ext_pin = ~ext_pin;
      rd_addr = 3'($urandom % 8);
      wr_en = ($urandom % 16) == 0;
      wr_addr = 3'($urandom % 6);
      wr_data = 8'($urandom);
    end
    @(negedge clk); wr_en = 0; presc_tick = 0; rd_addr = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule